// File: doc/BRIEF.md
# Keyboard Two-Wire Serial Link Engine

This block is the controller end of a two-wire, open-collector keyboard link made of a clock line and a data line. The keyboard drives the clock for every frame, in both directions. The engine takes in frames the keyboard sends and hands each received byte to the host logic as a valid/ready stream. Bytes the host logic sends arrive on a second valid/ready stream. For each such byte the engine takes the bus by holding the clock low, puts down a start bit, and then shifts the frame out on the clock edges the keyboard makes. Neither pad is ever driven high. The two outputs are only enables that pull the lines low, and the line levels come back in as inputs.

A frame has eleven bits, in this order:

- a start bit of 0
- eight data bits, least significant first
- an odd-parity bit
- a stop bit of 1

Every input passes through a two-flop synchronizer and a glitch filter before any edge is detected. All timing windows count microsecond ticks taken from a prescaler. These windows are the request-to-send hold, the acknowledge delay, and the receive and transmit timeouts.

Back-pressure: a received byte stays on `rx_data` with `rx_valid` high until `rx_ready` is seen high at a clock edge. Until then the engine holds the keyboard clock low, so the keyboard cannot send another frame, and it refuses new transmit bytes. On the transmit side, `tx_ready` is high only when the engine is idle, the link is not inhibited and no receive is under way. A byte is taken on the edge where `tx_valid` and `tx_ready` are both high.

Top module: `kbl_link`

## Requirements
- R1: A frame from the keyboard has a start bit of 0, eight data bits LSB first, a parity bit and a stop bit. Each bit is sampled on a falling clock edge. The frame is delivered as one byte on `rx_data` with `rx_valid` high.
- R2: A received frame whose nine data and parity bits hold an even number of ones sets `parity_err`, and the byte is still delivered. The flag clears at the start bit of the next received frame.
- R3: `rx_valid` rises no sooner than ACK_US microseconds after the eleventh falling edge, and within ACK_US plus the input pipeline delay.
- R4: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high, `rx_data` holds its value, `kb_clk_pull` is 1 and `tx_ready` is 0.
- R5: A transmit byte is taken on a valid/ready handshake. `kb_clk_pull` then stays 1 for at least RTS_US microseconds. When the clock is released, `kb_dat_pull` is already 1, which is the start bit.
- R6: After each keyboard falling edge while transmitting, the next bit appears on the data line: d0 to d7, then an odd-parity bit, then the stop bit, which is the line released. The eleventh falling edge ends the frame, after which `tx_ready` returns to 1 with the data line released.
- R7: If eleven falling edges have not arrived within TX_TO_US microseconds of the clock release, `tx_timeout` is set and both pulls are released. The flag clears at the next transmit handshake.
- R8: If a received frame is not complete within RX_TO_US microseconds of its start bit, `rx_timeout` is set and no byte is delivered. The flag clears at the next start bit.
- R9: While `inhibit_in` is 1 (after synchronizing), `inhibited` reads 1, `kb_clk_pull` is 1 and `tx_ready` is 0. When it returns to 0, the pull is released and `tx_ready` returns to 1.
- R10: A low pulse on the clock line shorter than FILT_LEN cycles is ignored and starts no frame.
- R11: After reset, both pulls are 0, `rx_valid` and all three error flags are 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_in | input | 1 | Level of the keyboard clock line |
| kb_dat_in | input | 1 | Level of the keyboard data line |
| kb_clk_pull | output | 1 | Pulls the clock line low when 1 |
| kb_dat_pull | output | 1 | Pulls the data line low when 1 |
| inhibit_in | input | 1 | Inhibit switch, 1 blocks the link |
| inhibited | output | 1 | Synchronized inhibit status |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine accepts a transmit byte |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Host logic takes the received byte |
| rx_data | output | 8 | Received byte |
| parity_err | output | 1 | Last received frame had even parity |
| rx_timeout | output | 1 | Last incoming frame was left incomplete |
| tx_timeout | output | 1 | Last transmit was not clocked out in time |

## Verification
The bench builds the engine with CLK_PER_US=1 and FILT_LEN=3, so that one cycle is one microsecond. It also cuts both timeouts to a few hundred microseconds. With this configuration, every one of the 256 byte values can be received in full, with a bad parity bit injected on a fixed stride, and a broad stride of byte values can be transmitted and checked bit by bit against arithmetic parity. The short timeouts, together with the keyboard model's exact edge timing, let the bench reach both timeout paths, the acknowledge window and the glitch filter threshold in a few thousand cycles.

// File: rtl/kbl_pkg.sv
package kbl_pkg;
  localparam int FRAME_BITS = 11;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_ACK,
    RX_HOLD
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_RTS,
    TX_REL,
    TX_BITS
  } tx_state_e;
endpackage

// File: rtl/kbl_us_tick.sv
module kbl_us_tick #(
  parameter int CLK_PER_US = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/kbl_line_filter.sv
module kbl_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= 2'b11;
      cnt   <= '0;
      level <= 1'b1;
    end else begin
      sync <= {sync[0], line_in};
      if (sync[1] == level) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        level <= sync[1];
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kbl_rx.sv
module kbl_rx
  import kbl_pkg::*;
#(
  parameter int RX_TO_US = 2000,
  parameter int ACK_US   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       fall,
  input  logic       dat,
  input  logic       rx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       parity_err,
  output logic       rx_timeout,
  output logic       busy,
  output logic       hold
);
  localparam int TMAX = (RX_TO_US > ACK_US) ? RX_TO_US : ACK_US;
  localparam int TW   = $clog2(TMAX + 1);

  rx_state_e     st;
  logic [3:0]    cnt;
  logic [TW-1:0] tmr;
  logic          pbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      cnt        <= '0;
      tmr        <= '0;
      pbit       <= 1'b0;
      rx_data    <= '0;
      parity_err <= 1'b0;
      rx_timeout <= 1'b0;
    end else begin
      unique case (st)
        RX_IDLE: begin
          if (en && fall && !dat) begin
            st         <= RX_SHIFT;
            cnt        <= '0;
            tmr        <= '0;
            parity_err <= 1'b0;
            rx_timeout <= 1'b0;
          end
        end
        RX_SHIFT: begin
          if (!en) begin
            st <= RX_IDLE;
          end else if (fall) begin
            cnt <= cnt + 1'b1;
            if (cnt < 4'd8) rx_data <= {dat, rx_data[7:1]};
            else if (cnt == 4'd8) pbit <= dat;
            if (cnt == 4'd9) begin
              st         <= RX_ACK;
              tmr        <= '0;
              parity_err <= ~(^{rx_data, pbit});
            end
          end else if (tick) begin
            if (tmr == TW'(RX_TO_US - 1)) begin
              rx_timeout <= 1'b1;
              st         <= RX_IDLE;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        RX_ACK: begin
          if (tick) begin
            if (tmr == TW'(ACK_US - 1)) st <= RX_HOLD;
            else tmr <= tmr + 1'b1;
          end
        end
        RX_HOLD: begin
          if (rx_ready) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign rx_valid = (st == RX_HOLD);
  assign hold     = (st == RX_HOLD);
  assign busy     = (st != RX_IDLE);
endmodule

// File: rtl/kbl_tx.sv
module kbl_tx
  import kbl_pkg::*;
#(
  parameter int RTS_US   = 100,
  parameter int TX_TO_US = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       can_start,
  input  logic       abort,
  input  logic       fall,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       clk_lo,
  output logic       dat_lo,
  output logic       busy,
  output logic       tx_timeout
);
  localparam int TMAX = (RTS_US > TX_TO_US) ? RTS_US : TX_TO_US;
  localparam int TW   = $clog2(TMAX + 1);

  tx_state_e     st;
  logic [3:0]    cnt;
  logic [TW-1:0] tmr;
  logic [7:0]    sr;
  logic          pbit;

  assign tx_ready = (st == TX_IDLE) && can_start;
  assign busy     = (st != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= TX_IDLE;
      cnt        <= '0;
      tmr        <= '0;
      sr         <= '0;
      pbit       <= 1'b0;
      clk_lo     <= 1'b0;
      dat_lo     <= 1'b0;
      tx_timeout <= 1'b0;
    end else if (st != TX_IDLE && abort) begin
      st     <= TX_IDLE;
      clk_lo <= 1'b0;
      dat_lo <= 1'b0;
    end else begin
      unique case (st)
        TX_IDLE: begin
          if (tx_valid && tx_ready) begin
            sr         <= tx_data;
            pbit       <= ~(^tx_data);
            st         <= TX_RTS;
            tmr        <= '0;
            tx_timeout <= 1'b0;
            clk_lo     <= 1'b1;
          end
        end
        TX_RTS: begin
          if (tick) begin
            if (tmr == TW'(RTS_US - 1)) begin
              dat_lo <= 1'b1;
              st     <= TX_REL;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        TX_REL: begin
          if (tick) begin
            clk_lo <= 1'b0;
            st     <= TX_BITS;
            tmr    <= '0;
            cnt    <= '0;
          end
        end
        TX_BITS: begin
          if (fall) begin
            cnt <= cnt + 1'b1;
            if (cnt < 4'd8) begin
              dat_lo <= ~sr[0];
              sr     <= {1'b0, sr[7:1]};
            end else if (cnt == 4'd8) begin
              dat_lo <= ~pbit;
            end else if (cnt == 4'd9) begin
              dat_lo <= 1'b0;
            end else begin
              st <= TX_IDLE;
            end
          end else if (tick) begin
            if (tmr == TW'(TX_TO_US - 1)) begin
              tx_timeout <= 1'b1;
              dat_lo     <= 1'b0;
              st         <= TX_IDLE;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kbl_link.sv
module kbl_link #(
  parameter int CLK_PER_US = 8,
  parameter int FILT_LEN   = 4,
  parameter int RTS_US     = 100,
  parameter int ACK_US     = 20,
  parameter int RX_TO_US   = 2000,
  parameter int TX_TO_US   = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_in,
  input  logic       kb_dat_in,
  output logic       kb_clk_pull,
  output logic       kb_dat_pull,
  input  logic       inhibit_in,
  output logic       inhibited,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       parity_err,
  output logic       rx_timeout,
  output logic       tx_timeout
);
  localparam int NLINES = 2;

  logic              tick;
  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] lvl;
  logic              clk_prev;
  logic              clk_fall;
  logic [1:0]        inh_sync;
  logic              rx_busy, rx_hold;
  logic              tx_busy, tx_clk_lo, tx_dat_lo;

  assign raw_lines = {kb_dat_in, kb_clk_in};

  kbl_us_tick #(.CLK_PER_US(CLK_PER_US)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    kbl_line_filter #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rst_n(rst_n), .line_in(raw_lines[g]), .level(lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b1;
      inh_sync <= 2'b00;
    end else begin
      clk_prev <= lvl[0];
      inh_sync <= {inh_sync[0], inhibit_in};
    end
  end

  assign clk_fall  = clk_prev && !lvl[0];
  assign inhibited = inh_sync[1];

  kbl_rx #(.RX_TO_US(RX_TO_US), .ACK_US(ACK_US)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .en(!inhibited && !tx_busy), .fall(clk_fall), .dat(lvl[1]),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .parity_err(parity_err), .rx_timeout(rx_timeout),
    .busy(rx_busy), .hold(rx_hold)
  );

  kbl_tx #(.RTS_US(RTS_US), .TX_TO_US(TX_TO_US)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .can_start(!inhibited && !rx_busy), .abort(inhibited),
    .fall(clk_fall), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .clk_lo(tx_clk_lo), .dat_lo(tx_dat_lo),
    .busy(tx_busy), .tx_timeout(tx_timeout)
  );

  assign kb_clk_pull = inhibited || rx_hold || tx_clk_lo;
  assign kb_dat_pull = tx_dat_lo;
endmodule

// File: rtl/kbl_link_chk.sv
module kbl_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       kb_clk_pull,
  input logic       kb_dat_pull,
  input logic       inhibited,
  input logic       parity_err,
  input logic       rx_timeout
);
  // R4
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R4
  rx_stall_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> kb_clk_pull && !tx_ready);

  // R9
  inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibited |-> kb_clk_pull && !tx_ready);

  // R5
  idle_dat_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !kb_dat_pull);

  // R8
  rx_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(parity_err && rx_timeout));
endmodule

bind kbl_link kbl_link_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .kb_clk_pull(kb_clk_pull),
  .kb_dat_pull(kb_dat_pull), .inhibited(inhibited),
  .parity_err(parity_err), .rx_timeout(rx_timeout)
);

// File: tb/kbl_link_tb_top.sv
module kbl_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RTS_US     = 100;
  localparam int ACK_US     = 20;
  localparam int RX_TO_US   = 300;
  localparam int TX_TO_US   = 400;
  localparam int HALF       = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kb_clk_k = 1'b1, kb_dat_k = 1'b1;
  logic kb_clk_in, kb_dat_in, kb_clk_pull, kb_dat_pull;
  logic inhibit_in = 1'b0, inhibited;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic parity_err, rx_timeout, tx_timeout;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign kb_clk_in = kb_clk_k & ~kb_clk_pull;
  assign kb_dat_in = kb_dat_k & ~kb_dat_pull;

  kbl_link #(
    .CLK_PER_US(1), .FILT_LEN(3), .RTS_US(RTS_US), .ACK_US(ACK_US),
    .RX_TO_US(RX_TO_US), .TX_TO_US(TX_TO_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .kb_clk_in(kb_clk_in), .kb_dat_in(kb_dat_in),
    .kb_clk_pull(kb_clk_pull), .kb_dat_pull(kb_dat_pull),
    .inhibit_in(inhibit_in), .inhibited(inhibited),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .parity_err(parity_err), .rx_timeout(rx_timeout), .tx_timeout(tx_timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // keyboard sends the first n bits of an 11-bit frame
  task automatic kb_frame(input logic [10:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      kb_dat_k = bits[i];
      idle(HALF/2);
      kb_clk_k = 1'b0;
      idle(HALF);
      kb_clk_k = 1'b1;
      idle(HALF/2);
    end
    kb_dat_k = 1'b1;
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit bad);
    return {1'b1, (~(^b)) ^ bad, b, 1'b0};
  endfunction

  // full receive with acknowledge timing and delivery checks
  task automatic rx_one(input logic [7:0] b, input bit bad);
    int w;
    idle(20);
    kb_frame(mk_frame(b, bad), 11);
    chk(rx_valid == 1'b0, "R3 early", rx_valid, 0);
    w = 0;
    while (!rx_valid && w < 40) begin
      @(negedge clk);
      w++;
    end
    chk(rx_valid == 1'b1, "R3 late", rx_valid, 1);
    chk(rx_data == b, "R1 data", rx_data, b);
    chk(parity_err == bad, "R2 parity flag", parity_err, bad);
    chk(kb_clk_pull == 1'b1, "R4 clock stall", kb_clk_pull, 1);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic tx_offer(input logic [7:0] b);
    int w;
    tx_data = b;
    tx_valid = 1'b1;
    w = 0;
    while (!tx_ready && w < 1000) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_one(input logic [7:0] b);
    int n;
    logic [9:0] got;
    logic [9:0] exp;
    idle(20);
    tx_offer(b);
    n = 0;
    while (kb_clk_pull && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk(n >= RTS_US, "R5 hold length", n, RTS_US);
    chk(kb_dat_pull == 1'b1, "R5 start bit", kb_dat_pull, 1);
    for (int i = 1; i <= 11; i++) begin
      idle(HALF/2);
      if (i == 11) kb_dat_k = 1'b0;
      kb_clk_k = 1'b0;
      idle(HALF);
      kb_clk_k = 1'b1;
      if (i <= 10) got[i-1] = kb_dat_in;
      idle(HALF/2);
      kb_dat_k = 1'b1;
    end
    exp = {1'b1, ~(^b), b};
    chk(got == exp, "R6 serial bits", got, exp);
    idle(20);
    chk(tx_ready == 1'b1 && kb_dat_pull == 1'b0, "R6 done", {tx_ready, kb_dat_pull}, 2);
    chk(tx_timeout == 1'b0, "R7 no timeout", tx_timeout, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R11
    chk(kb_clk_pull == 0 && kb_dat_pull == 0, "R11 pulls", {kb_clk_pull, kb_dat_pull}, 0);
    chk(rx_valid == 0 && parity_err == 0 && rx_timeout == 0 && tx_timeout == 0,
        "R11 flags", {rx_valid, parity_err, rx_timeout, tx_timeout}, 0);
    chk(tx_ready == 1, "R11 tx_ready", tx_ready, 1);

    // R1 R2 R3: every byte value, bad parity on a stride
    for (int b = 0; b < 256; b++) rx_one(8'(b), (b % 16) == 5);

    // R4: long back-pressure
    idle(20);
    kb_frame(mk_frame(8'h81, 1'b0), 11);
    idle(40);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 200; i++) begin
        if (!(rx_valid && rx_data == 8'h81 && kb_clk_pull && !tx_ready)) ok = 1'b0;
        @(negedge clk);
      end
      chk(ok, "R4 stall held", ok, 1);
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
    chk(rx_valid == 0, "R4 release", rx_valid, 0);

    // R8: partial frame
    idle(20);
    kb_frame(mk_frame(8'h3C, 1'b1), 4);
    idle(RX_TO_US + 40);
    chk(rx_timeout == 1 && rx_valid == 0, "R8 timeout", {rx_timeout, rx_valid}, 2);
    rx_one(8'hA5, 1'b0);
    chk(rx_timeout == 0, "R8 cleared", rx_timeout, 0);

    // R10: short clock glitches with data low start no frame
    idle(20);
    kb_dat_k = 1'b0;
    kb_clk_k = 1'b0; @(negedge clk); kb_clk_k = 1'b1;
    idle(5);
    kb_clk_k = 1'b0; idle(2); kb_clk_k = 1'b1;
    idle(5);
    kb_dat_k = 1'b1;
    idle(RX_TO_US + 40);
    chk(rx_valid == 0 && rx_timeout == 0, "R10 glitch", {rx_valid, rx_timeout}, 0);
    rx_one(8'h5A, 1'b0);

    // R5 R6: transmit sweep
    for (int b = 0; b < 256; b += 5) tx_one(8'(b));

    // R7: keyboard never clocks
    idle(20);
    tx_offer(8'hC3);
    idle(RTS_US + TX_TO_US + 30);
    chk(tx_timeout == 1, "R7 timeout set", tx_timeout, 1);
    chk(kb_clk_pull == 0 && kb_dat_pull == 0, "R7 lines freed", {kb_clk_pull, kb_dat_pull}, 0);
    chk(tx_ready == 1, "R7 ready again", tx_ready, 1);
    tx_one(8'h96);

    // R9: inhibit
    idle(20);
    inhibit_in = 1'b1;
    idle(5);
    chk(inhibited == 1, "R9 status", inhibited, 1);
    chk(kb_clk_pull == 1 && tx_ready == 0, "R9 block", {kb_clk_pull, tx_ready}, 2);
    tx_data = 8'h11;
    tx_valid = 1'b1;
    idle(50);
    chk(kb_dat_pull == 0 && tx_ready == 0, "R9 no send", {kb_dat_pull, tx_ready}, 0);
    tx_valid = 1'b0;
    inhibit_in = 1'b0;
    idle(5);
    chk(inhibited == 0 && kb_clk_pull == 0 && tx_ready == 1, "R9 restore",
        {inhibited, kb_clk_pull, tx_ready}, 1);
    rx_one(8'h42, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule